// File: doc/BRIEF.md
# Machine-Cycle Bus Sequencer with Refresh

This block generates the bus cycles of a small 8-bit processor that has no cache. A command port stands in for the instruction decoder. Each command asks for one of the following, and the block then drives the address lines, the write-data lines and the active-low strobes for the right number of clock states:

- an opcode fetch,
- a three-state memory read,
- a three-state memory write,
- an internal state that leaves the bus free,
- a stack push or a stack pop,
- a load of the stack pointer or of the refresh register.

Every opcode fetch takes two states. Two refresh states always follow it, so the shortest instruction is four clocks. During refresh the interrupt-page input goes on the upper address lines and the refresh register goes on the lower ones. The low seven bits of the refresh register advance after each refresh, which lets the block keep dynamic memory alive with no other circuitry.

A push is four fetch and refresh states, then one internal state that pre-decrements the 16-bit stack pointer, then two writes: 11 clocks in all. A pop reads from the pointer it already has and increments after each byte: 10 clocks in all.

A request is taken when `req_valid` is high at a rising edge while `busy` is low. `busy` then stays high for exactly the states of the sequence. `done` pulses for one cycle once the sequence ends, and at that point `result` and `sp` are up to date.

Top module: `bus_cycle_seq`

## Requirements
- R1: An opcode fetch (`req_op`=0) lasts 4 states. In states 1 and 2, `addr`=`req_addr`, `mreq_n`=0, `rd_n`=0 and `m1_n`=0. The value of `din` at the end of state 2 is returned as `result` = {8'h00, din}.
- R2: In states 3 and 4 of every opcode fetch, `addr`={`ipage`, refresh register}, `mreq_n`=0 and `rfsh_n`=0, while `rd_n`, `wr_n` and `m1_n` stay 1.
- R3: After each opcode fetch, bits 6:0 of the refresh register advance by one and wrap from 7F to 00. Bit 7 keeps its value. Command `req_op`=7 loads the register from `req_addr[7:0]` in one internal state.
- R4: A memory read (`req_op`=1) lasts 3 states with `addr`=`req_addr` and `mreq_n`=`rd_n`=0 in all three. The value of `din` at the end of state 3 becomes `result` = {8'h00, din}.
- R5: A memory write (`req_op`=2) lasts 3 states. In all three, `addr`=`req_addr`, `mreq_n`=0, `dout_en`=1 and `dout`=`req_wdata[7:0]`. `wr_n` is 0 only in states 2 and 3.
- R6: An internal state (`req_op`=3, and the single state of ops 6 and 7) drives `addr_en`=0, `addr`=0, `dout_en`=0, `dout`=0 and all strobes high.
- R7: A push (`req_op`=4) lasts 11 states: a fetch at `req_addr`, then one internal state, then a write of `req_wdata[15:8]` at SP-1, then a write of `req_wdata[7:0]` at SP-2, with 16-bit wrap. `sp` ends at SP-2.
- R8: A pop (`req_op`=5) lasts 10 states: a fetch, then a read at SP (low byte), then a read at SP+1 (high byte). `result`={high, low} and `sp` ends at SP+2.
- R9: `busy` is high from the cycle after acceptance for exactly the number of states in the sequence. `done` is a single-cycle pulse with `busy` low. A request raised while `busy` is high has no effect.
- R10: Command `req_op`=6 loads the stack pointer from `req_addr` in one internal state.
- R11: While reset is held, and right after it, `busy`=0, `done`=0, `addr_en`=0, all strobes are high, `sp`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request |
| req_op | input | 3 | Command code (0 fetch, 1 read, 2 write, 3 internal, 4 push, 5 pop, 6 load SP, 7 load refresh) |
| req_addr | input | 16 | Address or load value |
| req_wdata | input | 16 | Write byte (low) or push word |
| ipage | input | 8 | Upper address during refresh |
| din | input | 8 | Read data from memory |
| addr | output | 16 | Address bus |
| addr_en | output | 1 | Address and strobes are being driven |
| dout | output | 8 | Write data |
| dout_en | output | 1 | Write data is being driven |
| mreq_n | output | 1 | Memory request strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| m1_n | output | 1 | Opcode-fetch marker |
| rfsh_n | output | 1 | Refresh strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence just completed |
| result | output | 16 | Fetched opcode, read byte or popped word |
| sp | output | 16 | Stack pointer |

## Verification
The hardest cases to reach from the ports are those where the refresh register carries out of bit 6 while bit 7 is set, and where a push or pop moves the stack pointer across the 0000/FFFF boundary. The command port can load both registers directly, so the stimulus seeds the refresh register with FF and 7F and sets the pointer to 0001 before pushing and popping. A stray request is also raised part-way through a push, to show that it neither shortens nor extends the running sequence.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [2*DW-1:0] req_wdata,
  input  logic [AW-DW-1:0] ipage,
  input  logic [DW-1:0]   din,
  output logic [AW-1:0]   addr,
  output logic            addr_en,
  output logic [DW-1:0]   dout,
  output logic            dout_en,
  output logic            mreq_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic            m1_n,
  output logic            rfsh_n,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] result,
  output logic [AW-1:0]   sp
);
  localparam logic [2:0] OP_FETCH = 3'd0, OP_READ = 3'd1, OP_WRITE = 3'd2, OP_IDLE = 3'd3,
                         OP_PUSH = 3'd4, OP_POP = 3'd5, OP_SETSP = 3'd6, OP_LDR = 3'd7;
  localparam logic [1:0] TLAST = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_F1, S_F2, S_RF1, S_RF2, S_INT, S_MR, S_MW} st_t;

  st_t             st;
  logic [2:0]      op_q;
  logic [AW-1:0]   a_q, sp_q;
  logic [2*DW-1:0] wd_q, res_q;
  logic [DW-1:0]   rr;
  logic [1:0]      tc;
  logic            hi_q, done_q;

  wire fetch_rd = (st == S_F1) || (st == S_F2);
  wire refr     = (st == S_RF1) || (st == S_RF2);
  wire mr       = (st == S_MR);
  wire mw       = (st == S_MW);
  wire stk      = (op_q == OP_PUSH) || (op_q == OP_POP);
  wire accept   = req_valid && (st == S_IDLE);

  wire last = (st == S_RF2 && op_q == OP_FETCH) ||
              (st == S_INT && op_q != OP_PUSH) ||
              (mr && tc == TLAST && (op_q == OP_READ || hi_q)) ||
              (mw && tc == TLAST && (op_q == OP_WRITE || hi_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_IDLE;
      a_q    <= '0;
      wd_q   <= '0;
      sp_q   <= '0;
      res_q  <= '0;
      rr     <= '0;
      tc     <= '0;
      hi_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      unique case (st)
        S_IDLE: if (accept) begin
          op_q <= req_op;
          a_q  <= req_addr;
          wd_q <= req_wdata;
          tc   <= '0;
          hi_q <= 1'b0;
          unique case (req_op)
            OP_FETCH, OP_PUSH, OP_POP: st <= S_F1;
            OP_READ:                   st <= S_MR;
            OP_WRITE:                  st <= S_MW;
            default:                   st <= S_INT;
          endcase
        end
        S_F1: st <= S_F2;
        S_F2: begin
          res_q <= {{DW{1'b0}}, din};
          st    <= S_RF1;
        end
        S_RF1: st <= S_RF2;
        S_RF2: begin
          rr <= {rr[DW-1:RW], rr[RW-1:0] + 1'b1};
          if (op_q == OP_FETCH)     st <= S_IDLE;
          else if (op_q == OP_PUSH) st <= S_INT;
          else                      st <= S_MR;
        end
        S_INT: begin
          st <= S_IDLE;
          unique case (op_q)
            OP_PUSH: begin
              sp_q <= sp_q - 1'b1;
              st   <= S_MW;
            end
            OP_SETSP: sp_q <= a_q;
            OP_LDR:   rr   <= a_q[DW-1:0];
            default: ;
          endcase
        end
        S_MR: if (tc == TLAST) begin
          tc <= '0;
          if (op_q == OP_POP) begin
            sp_q <= sp_q + 1'b1;
            if (!hi_q) begin
              res_q[DW-1:0] <= din;
              hi_q          <= 1'b1;
            end else begin
              res_q[2*DW-1:DW] <= din;
              st               <= S_IDLE;
            end
          end else begin
            res_q <= {{DW{1'b0}}, din};
            st    <= S_IDLE;
          end
        end else tc <= tc + 1'b1;
        S_MW: if (tc == TLAST) begin
          tc <= '0;
          if (op_q == OP_PUSH && !hi_q) begin
            sp_q <= sp_q - 1'b1;
            hi_q <= 1'b1;
          end else st <= S_IDLE;
        end else tc <= tc + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire [AW-1:0] mem_a = stk ? sp_q : a_q;

  assign addr_en = fetch_rd | refr | mr | mw;
  assign addr    = fetch_rd ? a_q : refr ? {ipage, rr} : (mr | mw) ? mem_a : '0;
  assign mreq_n  = !addr_en;
  assign rd_n    = !(fetch_rd | mr);
  assign wr_n    = !(mw && tc != 2'd0);
  assign m1_n    = !fetch_rd;
  assign rfsh_n  = !refr;
  assign dout_en = mw;
  assign dout    = !mw ? '0 : (op_q == OP_PUSH && !hi_q) ? wd_q[2*DW-1:DW] : wd_q[DW-1:0];
  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign result  = res_q;
  assign sp      = sp_q;
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] addr,
  input logic          addr_en,
  input logic          dout_en,
  input logic          mreq_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          m1_n,
  input logic          rfsh_n,
  input logic          busy,
  input logic          done
);
  a_r9_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r2_refresh_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> (rd_n && m1_n && wr_n && !mreq_n));
  a_r2_refresh_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!rfsh_n && !$past(rfsh_n)) |-> (addr == $past(addr)));
  a_r1_m1_reads: assert property (@(posedge clk) disable iff (!rst_n)
    !m1_n |-> (!rd_n && !mreq_n));
  a_r5_write_data: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (dout_en && !mreq_n));
  a_r6_free_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_en |-> (mreq_n && rd_n && wr_n && rfsh_n && !dout_en));
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!rd_n, !wr_n, !rfsh_n}) <= 1);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !addr_en);
endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr(addr), .addr_en(addr_en),
  .dout_en(dout_en), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
  .rfsh_n(rfsh_n), .busy(busy), .done(done)
);

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [2:0] req_op = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic [7:0] ipage = 0;
  logic [7:0] din;
  logic [15:0] addr, result, sp;
  logic [7:0] dout;
  logic addr_en, dout_en, mreq_n, rd_n, wr_n, m1_n, rfsh_n, busy, done;

  always #2 clk = ~clk;

  bus_cycle_seq dut (.*);

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign din = mem(addr);

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [15:0] m_sp = 0, m_res = 0;
  logic [7:0]  m_r = 0;
  logic [30:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [30:0] rec(input bit en, input logic [15:0] a, input bit mq,
      input bit rd, input bit wr, input bit m1, input bit rf, input bit de, input logic [7:0] d);
    return {en, a, mq, rd, wr, m1, rf, de, d};
  endfunction

  task automatic add(input logic [30:0] r, input string tag);
    exp_q.push_back(r);
    tag_q.push_back(tag);
  endtask

  task automatic add_fetch(input logic [15:0] a);
    add(rec(1, a, 0, 0, 1, 0, 1, 0, 0), "R1 fetch");
    add(rec(1, a, 0, 0, 1, 0, 1, 0, 0), "R1 fetch");
    add(rec(1, {ipage, m_r}, 0, 1, 1, 1, 0, 0, 0), "R2 refresh");
    add(rec(1, {ipage, m_r}, 0, 1, 1, 1, 0, 0, 0), "R2 refresh");
    m_res = {8'h00, mem(a)};
    m_r = {m_r[7], m_r[6:0] + 7'd1};
  endtask

  task automatic add_rd(input logic [15:0] a, input string tag);
    for (int k = 0; k < 3; k++) add(rec(1, a, 0, 0, 1, 1, 1, 0, 0), tag);
  endtask

  task automatic add_wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    add(rec(1, a, 0, 1, 1, 1, 1, 1, d), tag);
    add(rec(1, a, 0, 1, 0, 1, 1, 1, d), tag);
    add(rec(1, a, 0, 1, 0, 1, 1, 1, d), tag);
  endtask

  task automatic run(input logic [2:0] op, input logic [15:0] a, input logic [15:0] wd,
                     input bit intrude);
    logic [7:0] lo;
    exp_q.delete();
    tag_q.delete();
    case (op)
      3'd0: add_fetch(a);
      3'd1: begin add_rd(a, "R4 read"); m_res = {8'h00, mem(a)}; end
      3'd2: add_wr(a, wd[7:0], "R5 write");
      3'd3: add(rec(0, 0, 1, 1, 1, 1, 1, 0, 0), "R6 internal");
      3'd4: begin
        add_fetch(a);
        add(rec(0, 0, 1, 1, 1, 1, 1, 0, 0), "R7 push internal");
        m_sp = m_sp - 16'd1;
        add_wr(m_sp, wd[15:8], "R7 push high");
        m_sp = m_sp - 16'd1;
        add_wr(m_sp, wd[7:0], "R7 push low");
      end
      3'd5: begin
        add_fetch(a);
        add_rd(m_sp, "R8 pop low");
        lo = mem(m_sp);
        m_sp = m_sp + 16'd1;
        add_rd(m_sp, "R8 pop high");
        m_res = {mem(m_sp), lo};
        m_sp = m_sp + 16'd1;
      end
      3'd6: begin add(rec(0, 0, 1, 1, 1, 1, 1, 0, 0), "R10 load sp"); m_sp = a; end
      default: begin add(rec(0, 0, 1, 1, 1, 1, 1, 0, 0), "R3 load refresh"); m_r = a[7:0]; end
    endcase
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; exp_q.size() > 0; i++) begin
      string t;
      t = tag_q.pop_front();
      chk(t, {1'b0, addr_en, addr, mreq_n, rd_n, wr_n, m1_n, rfsh_n, dout_en, dout},
          {1'b0, exp_q.pop_front()});
      chk("R9 busy during sequence", {busy, done}, {1'b1, 1'b0});
      if (intrude && i == 1) begin
        req_valid = 1; req_op = 3'd2; req_addr = 16'h5555; req_wdata = 16'h00CC;
      end
      if (i == 2) req_valid = 0;
      @(negedge clk);
    end
    chk("R9 done pulse", {busy, done}, {1'b0, 1'b1});
    chk("R8 result", result, m_res);
    chk("R7 sp", sp, m_sp);
    @(negedge clk);
    chk("R9 done single", {busy, done, addr_en}, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {busy, done, addr_en, mreq_n, rd_n, wr_n, m1_n, rfsh_n}, 8'b00011111);
    chk("R11 reset sp", sp, 16'h0000);
    chk("R11 reset result", result, 16'h0000);
    rst_n = 1;
    @(negedge clk);
    chk("R11 after reset", {busy, done, addr_en}, 3'b000);
    ipage = 8'h3C;
    run(3'd0, 16'h1234, 0, 0);
    run(3'd0, 16'hABCD, 0, 0);
    run(3'd1, 16'h0F0F, 0, 0);
    run(3'd2, 16'h8001, 16'h77A5, 0);
    run(3'd3, 16'hFFFF, 0, 0);
    ipage = 8'hC3;
    run(3'd7, 16'h00FF, 0, 0);
    run(3'd0, 16'h0100, 0, 0);
    run(3'd0, 16'h0101, 0, 0);
    run(3'd7, 16'h007F, 0, 0);
    run(3'd0, 16'h2222, 0, 0);
    run(3'd0, 16'h2223, 0, 0);
    run(3'd6, 16'h0001, 0, 0);
    run(3'd4, 16'h4000, 16'hBEEF, 1);
    run(3'd5, 16'h4001, 0, 0);
    run(3'd6, 16'h2000, 0, 0);
    run(3'd4, 16'h4002, 16'h1357, 0);
    run(3'd5, 16'h4003, 0, 1);
    for (int n = 0; n < 130; n++) begin
      ipage = n[7:0];
      run(3'd0, 16'(n * 37), 0, 0);
    end
    run(3'd1, 16'hFFFF, 0, 0);
    run(3'd2, 16'h0000, 16'h0001, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule